// File: doc/BRIEF.md
# VCO Sub-band Auto-calibration Controller

This controller chooses one of 32 tuning sub-bands for an integrated oscillator. It drives the 5-bit capacitor-select code, and its goal is an oscillator that sits just below the programmed target frequency when the control voltage is at mid-rail. Software starts a run with a rising edge on a start bit. For the whole run the controller holds the charge pump inhibited and forces the loop control node to mid-supply. It then runs a successive-approximation search that sets one code bit per comparison period, most significant bit first.

Each decision compares two pulse streams over one full comparison period: the reference-divider pulses and the feedback-divider pulses. A trial bit is kept only when the feedback stream produced fewer pulses than the reference stream in that period, which means the oscillator is still slow. The run takes seven full comparison periods: one settle period, five trial periods and one latch period. These follow a partial period used to align to the reference.

A manual override can place any code on the band output. The most recent search result can always be read back. A separate clear bit returns the state machine to idle.

Top module: `vco_band_cal`

## Requirements
- R1: The search result is the highest 5-bit code (0 to 31) whose feedback stream is slower than the reference. Slower means no feedback pulse between one reference pulse and the next, including the closing one. If no code is slower, the result is 0. The bits are decided from bit 4 down to bit 0.
- R2: A run starts only on a 0-to-1 change of `cal_start`. Holding the bit high does not start another run. A bit that is already high when reset is released starts nothing.
- R3: `cp_inhibit` and `vctrl_mid` are 1 for every cycle of a run and 0 when idle.
- R4: `cal_busy` rises in the cycle after the start edge is sampled. It stays 1 until the run completes, then returns to 0.
- R5: With the default settle length of one period, `cal_busy` stays high across exactly 8 reference pulses: one alignment pulse plus seven full periods. It falls in the cycle after the eighth pulse.
- R6: While `cal_clear` is 1, the controller is held in idle. `cal_busy`, `cp_inhibit` and `vctrl_mid` are 0 in the following cycle, and `search_code` keeps its value. A later start edge runs normally.
- R7: While `man_en` is 1, `band_code` equals `man_code`, also during a run.
- R8: `search_code` is 0 after reset. It changes only in the cycle in which a run completes.
- R9: With `man_en` at 0, `band_code` equals `search_code` when idle and shows the trial code during a run.
- R10: A start edge that arrives during a run is ignored. The run keeps its 8-pulse length, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cal_start | input | 1 | Start bit; a rising edge starts a run |
| cal_clear | input | 1 | Returns the state machine to idle while high |
| man_en | input | 1 | Selects the manual code for the band output |
| man_code | input | 5 | Manual band code |
| ref_pulse | input | 1 | One-cycle pulse from the reference divider |
| fb_pulse | input | 1 | One-cycle pulse from the feedback divider |
| band_code | output | 5 | Sub-band code applied to the oscillator |
| cal_busy | output | 1 | High while a run is in progress |
| cp_inhibit | output | 1 | Holds the charge pump off |
| vctrl_mid | output | 1 | Forces the control node to mid-supply |
| search_code | output | 5 | Readback of the last search result |

## Verification
The bench builds the block with its defaults: a 5-bit code, a 4-bit feedback counter and a one-period settle. At these values every run is exactly 8 reference pulses long, so the length can be checked directly.

The behavioural oscillator has a divided period of 60 minus the code, in clock cycles. Reference periods from 20 to 70 cycles then cover four kinds of result: all-ones, all-zeros, a result whose only set bit is the LSB, and mixed codes. A manual code held during a run makes every trial see the same slow oscillator, which must produce the all-ones result while the band output stays at the manual value.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_SETTLE,
        ST_TRIAL,
        ST_LATCH
    } cal_state_e;

    typedef struct packed {
        logic inhibit;
        logic mid;
    } loop_ctl_t;

endpackage

// File: rtl/vbc_edge.sv
module vbc_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic evt
);
    logic level_q;

    // Reset value 1: a bit already high at power-on gives no edge.
    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level;
    end

    assign evt = level & ~level_q;
endmodule

// File: rtl/vbc_window.sv
module vbc_window #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic below
);
    localparam logic [CNT_W:0] REF_PER_WIN = (CNT_W+1)'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   fb_total;

    always_ff @(posedge clk) begin
        if (rst || ref_pulse)
            cnt_q <= '0;
        else if (fb_pulse && cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    // A feedback pulse in the closing cycle still belongs to this window.
    assign fb_total = {1'b0, cnt_q} + {{CNT_W{1'b0}}, fb_pulse};
    assign below    = fb_total < REF_PER_WIN;
endmodule

// File: rtl/vbc_sar.sv
module vbc_sar
    import vbc_pkg::*;
#(
    parameter int CODE_W         = 5,
    parameter int SETTLE_PERIODS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              clear,
    input  logic              ref_pulse,
    input  logic              below,
    output logic              busy,
    output logic [CODE_W-1:0] trial,
    output logic [CODE_W-1:0] result
);
    localparam int IDX_W = $clog2(CODE_W + 1);
    localparam int SET_W = $clog2(SETTLE_PERIODS + 1);
    localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(CODE_W - 1);
    localparam logic [SET_W-1:0]  SET_END = SET_W'(SETTLE_PERIODS - 1);

    cal_state_e        state_q;
    logic [CODE_W-1:0] trial_q, trial_d, result_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SET_W-1:0]  set_q;

    always_comb begin
        trial_d = trial_q;
        if (!below) trial_d[idx_q] = 1'b0;
        if (idx_q != '0) trial_d[idx_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            trial_q  <= '0;
            result_q <= '0;
            idx_q    <= '0;
            set_q    <= '0;
        end else if (clear) begin
            state_q <= ST_IDLE;
            trial_q <= '0;
            idx_q   <= '0;
            set_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_evt) begin
                        state_q <= ST_ALIGN;
                        trial_q <= TOP_BIT;
                        idx_q   <= TOP_IDX;
                    end
                end
                ST_ALIGN: begin
                    if (ref_pulse) begin
                        state_q <= ST_SETTLE;
                        set_q   <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (ref_pulse) begin
                        if (set_q == SET_END) state_q <= ST_TRIAL;
                        else                  set_q   <= set_q + 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (ref_pulse) begin
                        trial_q <= trial_d;
                        if (idx_q == '0) state_q <= ST_LATCH;
                        else             idx_q   <= idx_q - 1'b1;
                    end
                end
                ST_LATCH: begin
                    if (ref_pulse) begin
                        result_q <= trial_q;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign trial  = trial_q;
    assign result = result_q;
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import vbc_pkg::*;
#(
    parameter int CODE_W         = 5,
    parameter int CNT_W          = 4,
    parameter int SETTLE_PERIODS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_start,
    input  logic              cal_clear,
    input  logic              man_en,
    input  logic [CODE_W-1:0] man_code,
    input  logic              ref_pulse,
    input  logic              fb_pulse,
    output logic [CODE_W-1:0] band_code,
    output logic              cal_busy,
    output logic              cp_inhibit,
    output logic              vctrl_mid,
    output logic [CODE_W-1:0] search_code
);
    logic              start_evt;
    logic              below;
    logic              busy;
    logic [CODE_W-1:0] trial;
    logic [CODE_W-1:0] result;
    loop_ctl_t         ctl;

    vbc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (cal_start),
        .evt   (start_evt)
    );

    vbc_window #(.CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .below     (below)
    );

    vbc_sar #(
        .CODE_W         (CODE_W),
        .SETTLE_PERIODS (SETTLE_PERIODS)
    ) u_sar (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt),
        .clear     (cal_clear),
        .ref_pulse (ref_pulse),
        .below     (below),
        .busy      (busy),
        .trial     (trial),
        .result    (result)
    );

    always_comb begin
        ctl.inhibit = busy;
        ctl.mid     = busy;
    end

    always_comb begin
        if (man_en)    band_code = man_code;
        else if (busy) band_code = trial;
        else           band_code = result;
    end

    assign cal_busy    = busy;
    assign cp_inhibit  = ctl.inhibit;
    assign vctrl_mid   = ctl.mid;
    assign search_code = result;
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cal_start,
    input logic              cal_clear,
    input logic              ref_pulse,
    input logic              cal_busy,
    input logic              cp_inhibit,
    input logic              vctrl_mid,
    input logic [CODE_W-1:0] search_code
);
    AST_START_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_busy) |-> $past(cal_start)); // R2

    AST_LOOP_HELD: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> (cp_inhibit && vctrl_mid)); // R3

    AST_ENDS_ON_REF: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && !ref_pulse && !cal_clear) |=> cal_busy); // R5

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        cal_clear |=> !cal_busy); // R6

    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(search_code) |-> $fell(cal_busy)); // R8
endmodule

bind vco_band_cal vbc_checker #(.CODE_W(CODE_W)) u_vbc_checker (
    .clk         (clk),
    .rst         (rst),
    .cal_start   (cal_start),
    .cal_clear   (cal_clear),
    .ref_pulse   (ref_pulse),
    .cal_busy    (cal_busy),
    .cp_inhibit  (cp_inhibit),
    .vctrl_mid   (vctrl_mid),
    .search_code (search_code)
);

// File: tb/vco_band_cal_bench.sv
module vco_band_cal_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_start = 1'b1;
    logic       cal_clear = 1'b0;
    logic       man_en = 1'b0;
    logic [4:0] man_code = '0;
    logic       ref_pulse;
    logic       fb_pulse;
    logic [4:0] band_code;
    logic       cal_busy, cp_inhibit, vctrl_mid;
    logic [4:0] search_code;

    int checks = 0;
    int errors = 0;
    int ref_len = 40;
    int ref_ctr = 0;
    int fb_ctr  = 0;

    always #2 clk = ~clk;

    // Behavioural oscillator and dividers: feedback period is 60 minus the
    // applied band code; the feedback divider restarts at each reference pulse.
    assign ref_pulse = (ref_ctr >= ref_len - 1);
    assign fb_pulse  = (fb_ctr == (60 - int'(band_code)) - 1);

    always @(posedge clk) begin
        ref_ctr <= ref_pulse ? 0 : ref_ctr + 1;
        fb_ctr  <= ref_pulse ? 0 : ((fb_ctr < 255) ? fb_ctr + 1 : fb_ctr);
    end

    vco_band_cal u_vco_band_cal (
        .clk(clk), .rst(rst), .cal_start(cal_start), .cal_clear(cal_clear),
        .man_en(man_en), .man_code(man_code), .ref_pulse(ref_pulse),
        .fb_pulse(fb_pulse), .band_code(band_code), .cal_busy(cal_busy),
        .cp_inhibit(cp_inhibit), .vctrl_mid(vctrl_mid), .search_code(search_code)
    );

    function automatic int exp_code(input int r);
        int best = 0;
        for (int c = 0; c < 32; c++) if (60 - c > r) best = c;
        return best;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Raise the start bit and follow the run until busy falls.
    task automatic do_run(input int rlen, output int refs, output int held,
                          output int man_ok);
        ref_len = rlen;
        repeat (2 * rlen + 2) @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        check("R4 busy after start edge", int'(cal_busy), 1);
        refs = 0; held = 1; man_ok = 1;
        for (int i = 0; i < 4000 && cal_busy; i++) begin
            if (ref_pulse) refs++;
            if (!(cp_inhibit && vctrl_mid)) held = 0;
            if (man_en && band_code != man_code) man_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state;
        check("R8 readback after reset", int'(search_code), 0);
        check("R9 band after reset", int'(band_code), 0);
        check("R4 idle after reset", int'(cal_busy), 0);
        check("R3 loop released after reset", int'(cp_inhibit | vctrl_mid), 0);
    endtask

    task automatic t_search(input int rlen);
        int refs, held, mo;
        cal_start = 1'b0;
        @(negedge clk);
        do_run(rlen, refs, held, mo);
        check("R5 reference pulses per run", refs, 8);
        check("R3 loop held during run", held, 1);
        check("R3 loop released after run", int'(cp_inhibit | vctrl_mid), 0);
        check("R1 search result", int'(search_code), exp_code(rlen));
        check("R9 band follows result", int'(band_code), int'(search_code));
        cal_start = 1'b0;
    endtask

    task automatic t_hold_high;
        int refs, held, mo, seen;
        cal_start = 1'b0;
        @(negedge clk);
        do_run(25, refs, held, mo);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            if (cal_busy) seen = 1;
            @(negedge clk);
        end
        check("R2 held start bit gives one run", seen, 0);
        cal_start = 1'b0;
    endtask

    task automatic t_restart_ignored;
        int refs, seen;
        cal_start = 1'b0;
        ref_len = 30;
        repeat (62) @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        refs = 0;
        for (int i = 0; i < 4000 && cal_busy; i++) begin
            if (ref_pulse) refs++;
            if (i == 90) cal_start = 1'b0;
            if (i == 92) cal_start = 1'b1;
            @(negedge clk);
        end
        check("R10 run length with extra edge", refs, 8);
        seen = 0;
        for (int i = 0; i < 150; i++) begin
            if (cal_busy) seen = 1;
            @(negedge clk);
        end
        check("R10 no second run", seen, 0);
        check("R10 result unaffected", int'(search_code), exp_code(30));
        cal_start = 1'b0;
    endtask

    task automatic t_clear;
        int prev, refs, held, mo;
        cal_start = 1'b0;
        ref_len = 40;
        repeat (82) @(negedge clk);
        prev = int'(search_code);
        cal_start = 1'b1;
        repeat (100) @(negedge clk);
        check("R4 busy mid run", int'(cal_busy), 1);
        cal_clear = 1'b1;
        @(negedge clk);
        check("R6 clear idles", int'(cal_busy), 0);
        check("R6 clear releases loop", int'(cp_inhibit | vctrl_mid), 0);
        check("R6 clear keeps readback", int'(search_code), prev);
        cal_clear = 1'b0;
        cal_start = 1'b0;
        @(negedge clk);
        do_run(40, refs, held, mo);
        check("R6 run after clear", refs, 8);
        check("R6 result after clear", int'(search_code), exp_code(40));
        cal_start = 1'b0;
    endtask

    task automatic t_manual;
        int refs, held, mo;
        cal_start = 1'b0;
        man_en = 1'b1;
        man_code = 5'd7;
        @(negedge clk);
        check("R7 manual code applied", int'(band_code), 7);
        do_run(45, refs, held, mo);
        check("R7 manual code held in run", mo, 1);
        check("R1 slow oscillator gives all ones", int'(search_code), 31);
        check("R7 manual code after run", int'(band_code), 7);
        man_en = 1'b0;
        @(negedge clk);
        check("R9 band back to result", int'(band_code), 31);
        cal_start = 1'b0;
    endtask

    initial begin
        int seen;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            if (cal_busy) seen = 1;
            @(negedge clk);
        end
        check("R2 start high through reset", seen, 0);
        t_reset_state();
        t_search(45);
        t_search(40);
        t_search(20);
        t_search(70);
        t_search(58);
        t_hold_high();
        t_restart_ignored();
        t_clear();
        t_manual();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R4 run end actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule